// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous static memory with 18-bit words. Each word is held as two 9-bit lanes, and each lane holds 8 data bits and 1 parity bit. The chip enable, both address strobes, the burst-advance input, the two byte write enables, the address and the write data are all captured on the rising clock edge. Only the output enable acts without the clock, and it gates nothing but the drive flag.

A cycle is started by one of two active-low address strobes. The processor-style strobe always loads the external address and reads it. The controller-style strobe loads the address and then reads or writes, depending on the byte write enables. Once a cycle is open, both strobes high lets the block continue. An active advance steps a 2-bit interleaved burst counter that XORs the low address bits of the loaded address. An inactive advance holds the present address as a wait cycle.

Read data passes straight through from the array, and the block has no tristate pins. Instead, a separate drive flag tells the surrounding logic when the data output may be driven.

Top module: `sbsram_core`

## Requirements
- R1: Byte write enable `we_n[0]` controls word bits 8:0 and `we_n[1]` controls bits 17:9. A lane whose enable is high keeps its stored value during a write.
- R2: `oe_n` acts asynchronously and only on `drive`. With `oe_n` high, `drive` is 0. Changing `oe_n` between clock edges changes `drive` with no clock edge.
- R3: With `ce_n` low and `adsp_n` low at an edge, the external address is loaded and a read is done, whatever `we_n` and `adsc_n` are.
- R4: With `ce_n` low, `adsc_n` low and `adsp_n` high, the external address is loaded. The cycle writes if either `we_n` bit is low; otherwise it reads.
- R5: With `ce_n` high and either strobe low, the block is deselected and `drive` is 0. While deselected, edges with both strobes high neither write nor read.
- R6: A burst changes only address bits 1:0. Beat k uses (loaded bits 1:0) XOR k, so a start of 11 gives 11, 10, 01, 00. The upper address bits stay those of the loaded address.
- R7: While selected with both strobes high, `adv_n` low moves to the next burst address and `adv_n` high keeps the current one. Either way the cycle reads, or writes the lanes whose `we_n` bit is low, at that address. A write directly after a processor-strobe read lands on the loaded address.
- R8: After the fourth beat, further advances wrap and repeat the same four addresses.
- R9: After any edge with `adsp_n` high and a `we_n` bit low, `drive` is 0. While reset is asserted, `drive` is 0.
- R10: `rdata` shows the array word at the address accessed on the most recent edge, during the following cycle. `drive` is 1 only when the block is selected, that access was a read, and `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| wdata | input | 18 | Write data, two 9-bit lanes |
| ce_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor-style address strobe, active low |
| adsc_n | input | 1 | Controller-style address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 2 | Byte write enables, active low, bit 0 for the low lane |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | 18 | Flow-through read data |
| drive | output | 1 | Output drive flag |

## Verification
The bench targets the strobe priority and the write path. A processor-strobe load with the write enables low must read: a design that let the enables through would overwrite the word and lower `drive`. It also checks a wait-cycle write after that load, which must hit the loaded address and not the next burst beat. Burst reads from two different start offsets past the fourth beat expose a linear counter or a missing wrap, because both would return the wrong words.

Single-lane writes expose any crossing of the lane enables. Edges while deselected, with the enables low, expose a write that leaks through: a later read of the neighbouring burst word would return corrupted data.
// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int BURST_W = 2;
  localparam int LANES   = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DESEL = 2'd3
  } acc_e;
endpackage
// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
(
  input  logic             ce_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] we_n,
  input  logic             sel_q,
  output acc_e             acc,
  output logic             load,
  output logic             step,
  output logic [LANES-1:0] wr_lane
);
  logic any_we;
  assign any_we = ~&we_n;

  // Strobe priority: deselect first, then processor strobe, then controller strobe.
  always_comb begin
    acc  = ACC_NONE;
    load = 1'b0;
    step = 1'b0;
    if ((!adsp_n || !adsc_n) && ce_n) begin
      acc = ACC_DESEL;
    end else if (!adsp_n) begin
      load = 1'b1;
      acc  = ACC_READ;
    end else if (!adsc_n) begin
      load = 1'b1;
      acc  = any_we ? ACC_WRITE : ACC_READ;
    end else if (sel_q) begin
      step = !adv_n;
      acc  = any_we ? ACC_WRITE : ACC_READ;
    end
  end

  assign wr_lane = (acc == ACC_WRITE) ? ~we_n : '0;
endmodule
// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               en;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = ext_addr;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign en       = load | step;
  assign acc_addr = {base_d[ADDR_W-1 -: HI_W], base_d[BURST_W-1:0] ^ cnt_d};
  assign cur_addr = {base_q[ADDR_W-1 -: HI_W], base_q[BURST_W-1:0] ^ cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule
// File: rtl/sbsram_lane.sv
module sbsram_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[wr_addr] <= wd;
  end

  assign rd = mem[rd_addr];
endmodule
// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      ce_n,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic [LANES-1:0]          we_n,
  input  logic                      oe_n,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      drive
);
  logic [1:0]        rst_pipe;
  logic              rst_q_n;
  logic              sel_q, sel_d;
  logic              rd_q, rd_d;
  acc_e              acc;
  logic              load, step;
  logic [LANES-1:0]  wr_lane;
  logic [ADDR_W-1:0] acc_addr, cur_addr;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  sbsram_decode u_decode (
    .ce_n    (ce_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .we_n    (we_n),
    .sel_q   (sel_q),
    .acc     (acc),
    .load    (load),
    .step    (step),
    .wr_lane (wr_lane)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .step     (step),
    .ext_addr (addr),
    .acc_addr (acc_addr),
    .cur_addr (cur_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .wr      (wr_lane[g]),
      .wr_addr (acc_addr),
      .wd      (wdata[g*LANE_W +: LANE_W]),
      .rd_addr (cur_addr),
      .rd      (rdata[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    sel_d = sel_q;
    rd_d  = rd_q;
    if (load)                 sel_d = 1'b1;
    else if (acc == ACC_DESEL) sel_d = 1'b0;
    case (acc)
      ACC_READ:            rd_d = 1'b1;
      ACC_WRITE, ACC_DESEL: rd_d = 1'b0;
      default:             rd_d = rd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rd_q  <= rd_d;
    end
  end

  assign drive = sel_q & rd_q & ~oe_n;
endmodule
// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic [1:0]        we_n,
  input logic              oe_n,
  input logic              drive,
  input logic              sel_q,
  input logic [ADDR_W-1:0] cur_addr
);
  p_oe_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive);

  p_adsp_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && !adsp_n) |-> (cur_addr == $past(addr)) && sel_q);

  p_adsp_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ce_n && !adsp_n) && !oe_n) |-> drive);

  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past((!adsp_n || !adsc_n) && ce_n) |-> (!drive && !sel_q));

  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adsp_n && adsc_n) |-> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adsp_n && adsc_n && adv_n) |-> $stable(cur_addr));

  p_write_nodrive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adsp_n && !(&we_n)) |-> !drive);
endmodule

bind sbsram_core sbsram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .addr     (addr),
  .ce_n     (ce_n),
  .adsp_n   (adsp_n),
  .adsc_n   (adsc_n),
  .adv_n    (adv_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .drive    (drive),
  .sel_q    (sel_q),
  .cur_addr (cur_addr)
);
// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  typedef struct packed {
    logic        ce_n;
    logic        adsp_n;
    logic        adsc_n;
    logic        adv_n;
    logic [1:0]  we_n;
    logic        oe_n;
    logic [5:0]  addr;
    logic [17:0] wd;
    logic [1:0]  chk;     // 0 none, 1 drive only, 2 drive and data
    logic        exp_drv;
    logic [17:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    // R4: controller strobe write at 0x09, then R7 continue writes 0x08, 0x0B, 0x0A
    '{1'b0,1'b1,1'b0,1'b1,2'b00,1'b0,6'h09,18'h10001,2'd1,1'b0,18'h0,4'd4},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'h00,18'h20002,2'd1,1'b0,18'h0,4'd7},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'h00,18'h30003,2'd1,1'b0,18'h0,4'd7},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'h00,18'h04004,2'd1,1'b0,18'h0,4'd7},
    // R3: processor strobe with write enables low still reads 0x09
    '{1'b0,1'b0,1'b1,1'b1,2'b00,1'b0,6'h09,18'h3FFFF,2'd2,1'b1,18'h10001,4'd3},
    // R6: interleaved beat to 0x08; R7 wait cycle holds 0x08
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h20002,4'd6},
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h20002,4'd7},
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h30003,4'd6},
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h04004,4'd6},
    // R8: fifth beat wraps to the start address 0x09
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h10001,4'd8},
    // R2: output enable high keeps drive low
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b1,6'h00,18'h0,2'd1,1'b0,18'h0,4'd2},
    // R3: reload 0x09 by processor strobe
    '{1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,6'h09,18'h0,2'd2,1'b1,18'h10001,4'd3},
    // R9 / R1: low lane write in wait cycle, then read back
    '{1'b0,1'b1,1'b1,1'b1,2'b10,1'b0,6'h00,18'h3FFAA,2'd1,1'b0,18'h0,4'd9},
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h101AA,4'd1},
    // R9 / R1: high lane write, then read back
    '{1'b0,1'b1,1'b1,1'b1,2'b01,1'b0,6'h00,18'h2AA55,2'd1,1'b0,18'h0,4'd9},
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h2ABAA,4'd1},
    // R5: deselect, then a would-be write while deselected
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,6'h00,18'h0,2'd1,1'b0,18'h0,4'd5},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'h00,18'h3FFFF,2'd1,1'b0,18'h0,4'd5},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,6'h09,18'h0,2'd2,1'b1,18'h2ABAA,4'd5},
    // R4: controller strobe read of 0x0B
    '{1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,6'h0B,18'h0,2'd2,1'b1,18'h30003,4'd4},
    // R3: both strobes low with enables low: read wins, nothing written
    '{1'b0,1'b0,1'b0,1'b1,2'b00,1'b0,6'h0A,18'h0,2'd2,1'b1,18'h04004,4'd3},
    '{1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,6'h0A,18'h0,2'd2,1'b1,18'h04004,4'd3},
    // R6 / R10: burst from 0x0B: 0x0B, 0x0A, 0x09, 0x08
    '{1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,6'h0B,18'h0,2'd2,1'b1,18'h30003,4'd10},
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h04004,4'd6},
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h2ABAA,4'd6},
    '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,2'd2,1'b1,18'h20002,4'd6}
  };

  logic        clk, rst_n;
  logic [AW-1:0] addr;
  logic [17:0] wdata, rdata;
  logic        ce_n, adsp_n, adsc_n, adv_n, oe_n, drive;
  logic [1:0]  we_n;
  int          errors, checks;
  bit          done;

  sbsram_core #(.ADDR_W(AW), .LANE_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .rdata(rdata), .drive(drive)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ce_n = 1'b1; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    we_n = 2'b11; oe_n = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 18'd0, 18'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    errors = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R9: drive low while reset is asserted
    check(drive === 1'b0, "R9", {17'd0, drive}, 18'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(drive === 1'b0, "R9", {17'd0, drive}, 18'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ce_n = VEC[i].ce_n; adsp_n = VEC[i].adsp_n; adsc_n = VEC[i].adsc_n;
      adv_n = VEC[i].adv_n; we_n = VEC[i].we_n; oe_n = VEC[i].oe_n;
      addr = VEC[i].addr; wdata = VEC[i].wd;
      @(posedge clk);
      #1;
      if (VEC[i].chk != 2'd0)
        check(drive === VEC[i].exp_drv, $sformatf("R%0d drive step %0d", VEC[i].req, i),
              {17'd0, drive}, {17'd0, VEC[i].exp_drv});
      if (VEC[i].chk == 2'd2)
        check(rdata === VEC[i].exp_rd, $sformatf("R%0d data step %0d", VEC[i].req, i),
              rdata, VEC[i].exp_rd);
    end

    // R2: output enable acts between edges
    @(negedge clk);
    adv_n = 1'b1;
    #1 oe_n = 1'b1;
    #1 check(drive === 1'b0, "R2 oe high", {17'd0, drive}, 18'd0);
    oe_n = 1'b0;
    #1 check(drive === 1'b1, "R2 oe low", {17'd0, drive}, 18'd1);
    // R10: wait-cycle read still presents 0x08
    check(rdata === 18'h20002, "R10", rdata, 18'h20002);

    // R9: reset in mid-read drops drive at once
    rst_n = 1'b0;
    #1 check(drive === 1'b0, "R9 reset", {17'd0, drive}, 18'd0);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule